// File: doc/BRIEF.md
# Interval Timer Channel with Compare Flag

This block is one channel of a general-purpose hardware timer, reached through a plain register port: a write strobe with address and data, and a read port whose data follows the address in the same cycle. Software chooses the count direction and one of two run modes, then sets an interval and an optional compare value. Setting the run bit starts the counter. A single-run timer stops when it reaches its end value. A repeating timer reloads and keeps going.

Two events are recorded as sticky flags: the end of an interval and the counter equalling the compare value. Each flag is cleared by writing a one to its bit in a clear register. A mask register decides which flags reach the single interrupt line, and software can read the flags either raw or after masking. While the channel runs, the mode and interval registers are locked, so a running count is never changed by a configuration write.

Top module: `gptimer_chan`

## Requirements
- R1: After reset every register reads 0, including the run bit, the counter value and both flags, and `irq` is low.
- R2: Register map (word addresses): 0 run control (bit 0 = run), 1 mode, 2 interval, 3 compare, 4 counter value (read only), 5 interrupt mask, 6 raw flags (read only), 7 masked flags (read only), 8 flag clear (write only). When the run bit goes from 0 to 1, the counter loads 0 if counting up or the interval value if counting down. After that it changes by one on every clock edge in the chosen direction. Mode bit 4 set selects counting up.
- R3: The end value is the interval when counting up and 0 when counting down. On the edge after the counter holds the end value while running, the interval flag is set. This flag is bit 0 in the mask, raw-flag, masked-flag and clear registers.
- R4: Mode field bits [1:0] = 1 selects a single run. At the interval event the run bit clears and the counter holds the end value. Writing the run bit again restarts the count from the start value.
- R5: Mode field = 2 selects a repeating run. At the interval event the counter reloads the start value and keeps running, so an event occurs every interval+1 cycles.
- R6: With mode field 0 or 3, setting the run bit loads the start value, but the counter does not move and no flag is set.
- R7: When mode bit 5 is set and the running counter equals the compare value, the compare flag (bit 4 in the mask, raw-flag, masked-flag and clear registers) is set on the next edge. When mode bit 5 is clear, the compare flag is never set.
- R8: Writing a 1 to a bit of the clear register clears that flag. Writing a 0 leaves it unchanged. An event in the same cycle as the clear wins, and the flag stays set.
- R9: The masked-flag register reads raw flags AND mask. `irq` is high whenever any masked flag is set.
- R10: Writes to the mode and interval registers are ignored while the run bit is set.
- R11: Writing 0 to the run bit stops the counter, which then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Word address for writes and reads |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt, OR of the masked flags |

## Verification
A register write takes effect on the clock edge that ends its cycle. A read shows the state left by the previous edge, so a counter value read k cycles after the run-bit write equals the start value moved by k-1 steps. An interval or compare flag becomes visible one edge after the counter sits at the triggering value. Each bench action takes exactly one clock, and every expected value is worked out from how many edges lie between the run-bit write and the read. The scoreboard compares each expected item one nanosecond before the edge that would change it.

// File: rtl/gptimer_chan.sv
module gptimer_chan #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTL  = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);
  localparam logic [AW-1:0] A_LOAD = AW'(2);
  localparam logic [AW-1:0] A_CMP  = AW'(3);
  localparam logic [AW-1:0] A_CNT  = AW'(4);
  localparam logic [AW-1:0] A_MSK  = AW'(5);
  localparam logic [AW-1:0] A_RAW  = AW'(6);
  localparam logic [AW-1:0] A_MIS  = AW'(7);
  localparam logic [AW-1:0] A_CLR  = AW'(8);
  localparam logic [1:0] M_ONCE = 2'd1;
  localparam logic [1:0] M_REP  = 2'd2;

  logic         en, up, mie, msk_to, msk_mt, st_to, st_mt;
  logic [1:0]   mode;
  logic [W-1:0] load, cmp, cnt;

  logic wr_ctl, wr_clr, cfg_ok, run, at_term, to_evt, mt_evt;
  logic [W-1:0] start;

  assign wr_ctl  = wr_en && addr == A_CTL;
  assign wr_clr  = wr_en && addr == A_CLR;
  assign cfg_ok  = wr_en && !en;
  assign run     = en && (mode == M_ONCE || mode == M_REP);
  assign start   = up ? '0 : load;
  assign at_term = up ? (cnt == load) : (cnt == '0);
  assign to_evt  = run && !wr_ctl && at_term;
  assign mt_evt  = run && !wr_ctl && mie && cnt == cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mode <= '0;
      up   <= 1'b0;
      mie  <= 1'b0;
      load <= '0;
      cmp  <= '0;
      cnt  <= '0;
    end else begin
      if (cfg_ok && addr == A_MODE) begin
        mode <= wdata[1:0];
        up   <= wdata[4];
        mie  <= wdata[5];
      end
      if (cfg_ok && addr == A_LOAD) load <= wdata;
      if (wr_en && addr == A_CMP) cmp <= wdata;

      if (wr_ctl) begin
        en <= wdata[0];
        if (wdata[0] && !en) cnt <= start;
      end else if (run) begin
        if (at_term) begin
          if (mode == M_REP) cnt <= start;
          else en <= 1'b0;
        end else begin
          cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msk_to <= 1'b0;
      msk_mt <= 1'b0;
      st_to  <= 1'b0;
      st_mt  <= 1'b0;
    end else begin
      if (wr_en && addr == A_MSK) begin
        msk_to <= wdata[0];
        msk_mt <= wdata[4];
      end
      st_to <= to_evt || (st_to && !(wr_clr && wdata[0]));
      st_mt <= mt_evt || (st_mt && !(wr_clr && wdata[4]));
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = W'(en);
      A_MODE:  rdata = W'({mie, up, 2'b00, mode});
      A_LOAD:  rdata = load;
      A_CMP:   rdata = cmp;
      A_CNT:   rdata = cnt;
      A_MSK:   rdata = W'({msk_mt, 3'b000, msk_to});
      A_RAW:   rdata = W'({st_mt, 3'b000, st_to});
      A_MIS:   rdata = W'({st_mt & msk_mt, 3'b000, st_to & msk_to});
      default: rdata = '0;
    endcase
  end

  assign irq = (st_to && msk_to) || (st_mt && msk_mt);
endmodule

// File: rtl/gptimer_chan_chk.sv
module gptimer_chan_chk #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic          irq,
  input logic          en,
  input logic          up,
  input logic [1:0]    mode,
  input logic [W-1:0]  load,
  input logic [W-1:0]  cnt,
  input logic          st_to,
  input logic          st_mt,
  input logic          at_term,
  input logic          to_evt
);
  localparam logic [AW-1:0] C_CTL = AW'(0);
  localparam logic [AW-1:0] C_CLR = AW'(8);

  logic pv;
  logic ctl_w;
  assign ctl_w = wr_en && addr == C_CTL;

  always_ff @(posedge clk) begin
    if (!rst_n) pv <= 1'b0;
    else pv <= 1'b1;
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(en) && !$past(ctl_w) && $past(mode[0] ^ mode[1]) && !$past(at_term))
      |-> cnt == ($past(up) ? $past(cnt) + 1'b1 : $past(cnt) - 1'b1));

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(to_evt)) |-> st_to);

  p_once_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(to_evt) && $past(mode) == 2'd1) |-> (!en && cnt == $past(cnt)));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(to_evt) && $past(mode) == 2'd2)
      |-> (en && cnt == ($past(up) ? W'(0) : $past(load))));

  p_idle_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(en) && !$past(ctl_w) && ($past(mode) == 2'd0 || $past(mode) == 2'd3))
      |-> ($stable(cnt) && !$rose(st_to) && !$rose(st_mt)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(wr_en && addr == C_CLR && wdata[0] && !to_evt)) |-> !st_to);

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_to || st_mt));

  p_cfg_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(en)) |-> (mode == $past(mode) && load == $past(load)));

  p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && !$past(en) && !en) |-> cnt == $past(cnt));
endmodule

bind gptimer_chan gptimer_chan_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .en(en), .up(up), .mode(mode), .load(load), .cnt(cnt),
  .st_to(st_to), .st_mt(st_mt), .at_term(at_term), .to_evt(to_evt)
);

// File: tb/sim_gptimer_chan.sv
`timescale 1ns/1ps
module sim_gptimer_chan;
  localparam logic [3:0] CTL = 4'd0, MODE = 4'd1, LOAD = 4'd2, CMP = 4'd3,
                         CNT = 4'd4, MSK = 4'd5, RAW = 4'd6, MIS = 4'd7, CLR = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [3:0]  a;
    logic [31:0] e;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  gptimer_chan #(.W(32), .AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    q.push_back('{1'b0, a, e, tag});
  endtask

  task automatic ck_irq(input logic e, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    q.push_back('{1'b1, 4'd0, {31'b0, e}, tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? {31'b0, irq} : rdata;
        checks++;
        if (act !== it.e) begin
          fails++;
          $display("FAIL %s: addr %0d actual 0x%0h expected 0x%0h", it.tag, it.a, act, it.e);
        end
      end
    end
  end

  task automatic run_tests();
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    rd(CTL, 0, "R1 run bit");
    rd(MODE, 0, "R1 mode");
    rd(LOAD, 0, "R1 interval");
    rd(CNT, 0, "R1 counter");
    rd(RAW, 0, "R1 flags");
    ck_irq(1'b0, "R1 irq");

    wr(MODE, 32'h31); wr(LOAD, 5); wr(CMP, 2); wr(MSK, 32'h11);
    wr(CTL, 1);
    rd(CNT, 0, "R2 up start");
    rd(CNT, 1, "R2 up step");
    rd(RAW, 32'h00, "R7 compare not yet");
    rd(RAW, 32'h10, "R7 compare flag");
    ck_irq(1'b1, "R9 irq on compare");
    rd(CNT, 5, "R3 up end value");
    rd(RAW, 32'h11, "R3 interval flag up");
    rd(CTL, 0, "R4 run bit cleared");
    rd(CNT, 5, "R4 counter holds");
    wr(CLR, 32'h00);
    rd(RAW, 32'h11, "R8 zero write");
    wr(CLR, 32'h10);
    rd(RAW, 32'h01, "R8 clear compare");
    wr(MSK, 32'h10);
    rd(MIS, 32'h00, "R9 masked off");
    ck_irq(1'b0, "R9 irq masked");
    wr(MSK, 32'h01);
    rd(MIS, 32'h01, "R9 masked on");
    ck_irq(1'b1, "R9 irq on interval");
    wr(CLR, 32'h01);
    rd(RAW, 32'h00, "R8 clear interval");

    wr(MODE, 32'h02); wr(LOAD, 3);
    wr(CTL, 1);
    rd(CNT, 3, "R2 down start");
    wr(LOAD, 9);
    wr(MODE, 32'h01);
    rd(CNT, 0, "R3 down end value");
    rd(CNT, 3, "R5 reload");
    rd(RAW, 32'h01, "R3 interval flag down");
    rd(LOAD, 3, "R10 interval locked");
    rd(MODE, 32'h02, "R10 mode locked");
    wr(CLR, 32'h01);
    rd(RAW, 32'h00, "R8 cleared while running");
    rd(CNT, 1, "R5 second period");
    rd(CNT, 0, "R5 second end");
    rd(RAW, 32'h01, "R5 period event, R7 compare disabled");
    wr(CLR, 32'h01);
    rd(RAW, 32'h00, "R8 clear again");
    wr(CLR, 32'h01);
    rd(RAW, 32'h01, "R8 event beats clear");
    wr(CTL, 0);
    rd(CNT, 2, "R11 stop value");
    idle(3);
    rd(CNT, 2, "R11 counter held");
    rd(CTL, 0, "R11 run bit off");

    wr(CLR, 32'h11);
    wr(MODE, 32'h10); wr(LOAD, 4);
    wr(CTL, 1);
    idle(6);
    rd(CNT, 0, "R6 counter still");
    rd(RAW, 0, "R6 no flags");
    wr(CTL, 0);
    wr(MODE, 32'h11);
    wr(CTL, 1);
    rd(CNT, 0, "R4 restart value");
    idle(5);
    rd(RAW, 32'h01, "R4 second single run");
    rd(CTL, 0, "R4 stopped again");
    idle(3);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          fails++;
          checks++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule